// File: doc/BRIEF.md
# Half-Band Rate-Change Filter Core

This block is a linear-phase half-band low-pass FIR with 55 taps. It sits between a sample source and a downstream rounding and limiting stage. It runs in one of three rates. In pass-through, one result is produced for every input sample. In 1:2 interpolation, every second input slot is replaced by a zero. In 2:1 decimation, the output register loads only on every second clock edge. The result is left at full internal precision, so no rounding, limiting or output formatting is done here. A strobe marks each cycle in which the result register holds a freshly loaded value.

The symmetric coefficient set is given as two parameters: the centre tap, and the odd-offset taps listed outward from the centre. Every even-offset tap other than the centre is zero, so the core pre-adds each mirrored pair of samples and needs only one multiplier per pair. A two-state phase machine decides which edges are "take" edges. Its state `PH_TAKE` means the next edge takes a sample. Its state `PH_SKIP` means the next edge skips unless a realignment occurs. Three transitions are named:

- `advance`: `PH_TAKE` to `PH_SKIP`.
- `return`: `PH_SKIP` to `PH_TAKE` when no mark falls.
- `realign`: a fall of the phase mark, taken from either state. The falling edge itself becomes a take edge, and the machine moves to `PH_SKIP`.

Top module: `hb_rate_filter`

## Requirements
- R1: The mode is decoded from {mode_a, mode_b}: 2'b01 selects interpolation, 2'b10 selects decimation, and 2'b00 and 2'b11 both select pass-through.
- R2: In pass-through, the result register loads on every clock edge, so acc_stb is 1 on every cycle after the first edge out of reset.
- R3: A sample presented before edge m enters the delay line at edge m. The result loaded at edge E equals the sum over k = 0..54 of c[k]·s(E−1−k), where s(m) is the value stored at edge m and 0 before reset release.
- R4: The coefficients are symmetric about index 27, with c[27] = CENTRE and c[27−(2i+1)] = c[27+(2i+1)] = ODD[i] for i = 0..13. All other taps are 0. An impulse A in pass-through therefore gives A·CENTRE in the result 28 edges after it is taken, and A·ODD[0] one edge before and one edge after that.
- R5: In interpolation mode, the sample presented on a skip edge is stored as zero. The sample presented on a take edge is stored unchanged.
- R6: In decimation mode, the result register loads only on take edges and holds otherwise. acc_stb is 1 exactly in the cycle after each load.
- R7: Without realignment, take and skip edges alternate. The first edge after reset release is a take edge.
- R8: An edge at which phase_mark is 0, and was 1 at the previous edge, is a take edge. The word presented with it is the first aligned word. Holding phase_mark at 0, or toggling it every cycle, keeps that alignment.
- R9: In pass-through, phase_mark has no effect on acc_out or acc_stb.
- R10: A synchronous active-high rst clears the delay line, sets acc_out to 0 and acc_stb to 0, and returns the phase machine to PH_TAKE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 12 | Two's complement input sample |
| mode_a | input | 1 | Mode select, upper bit |
| mode_b | input | 1 | Mode select, lower bit |
| phase_mark | input | 1 | Phase alignment mark; a 1-then-0 pattern marks a take edge |
| acc_out | output | 36 | Full-precision signed filter result |
| acc_stb | output | 1 | High for the cycle after the result register loads |

## Verification
A sample driven before edge m first reaches the result at edge m+1, through tap 0. It moves one tap later with each further edge, so the centre coefficient appears 28 edges after the sample is taken. The strobe rises in the cycle right after each load. The bench's behavioural model updates its history and expected result at each rising edge. Both outputs are compared at the following falling edge, which is the first settled point after the edge that loaded them. The impulse checks count edges from the taking edge to the centre and to both neighbouring taps.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        MODE_PASS   = 2'd0,
        MODE_INTERP = 2'd1,
        MODE_DECIM  = 2'd2
    } hb_mode_e;

    typedef enum logic {
        PH_TAKE = 1'b0,
        PH_SKIP = 1'b1
    } hb_phase_e;

    // R1: mode decode; both equal settings mean pass-through
    function automatic hb_mode_e decode_mode(input logic a, input logic b);
        hb_mode_e m;
        unique case ({a, b})
            2'b01:   m = MODE_INTERP;
            2'b10:   m = MODE_DECIM;
            default: m = MODE_PASS;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/hb_phase_ctl.sv
module hb_phase_ctl
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic phase_mark,
    output logic take
);

    hb_phase_e state, state_nx;
    logic      mark_q;
    logic      mark_fall;

    assign mark_fall = mark_q & ~phase_mark;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_TAKE: state_nx = PH_SKIP;                         // advance
            PH_SKIP: state_nx = mark_fall ? PH_SKIP : PH_TAKE;   // realign / return
            default: state_nx = PH_TAKE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PH_TAKE;
            mark_q <= 1'b0;
        end else begin
            state  <= state_nx;
            mark_q <= phase_mark;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            PH_TAKE: take = 1'b1;
            PH_SKIP: take = mark_fall;
            default: take = 1'b1;
        endcase
    end

    // R7
    alt_phase_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (mark_fall || !take));

    // R8
    mark_take_chk: assert property (@(posedge clk) disable iff (rst)
        (mark_q && !phase_mark) |-> take);

endmodule

// File: rtl/hb_tap_line.sv
module hb_tap_line #(
    parameter int DW   = 12,
    parameter int NODD = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] din,
    input  logic                 zero_in,
    output logic signed [DW-1:0] pair_lo [NODD],
    output logic signed [DW-1:0] pair_hi [NODD],
    output logic signed [DW-1:0] mid
);

    localparam int NTAP = 4 * NODD - 1;
    localparam int MID  = 2 * NODD - 1;

    logic signed [DW-1:0] sh [NTAP];

    always_ff @(posedge clk) begin
        if (rst)          sh[0] <= '0;
        else if (zero_in) sh[0] <= '0;
        else              sh[0] <= din;
    end

    for (genvar k = 1; k < NTAP; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sh[k] <= '0;
            else     sh[k] <= sh[k-1];
        end
    end

    for (genvar i = 0; i < NODD; i++) begin : g_pick
        assign pair_lo[i] = sh[MID - (2*i + 1)];
        assign pair_hi[i] = sh[MID + (2*i + 1)];
    end

    assign mid = sh[MID];

    // R5
    stuff_zero_chk: assert property (@(posedge clk) disable iff (rst)
        zero_in |=> (sh[0] == '0));

    // R3
    shift_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sh[1] == $past(sh[0])));

endmodule

// File: rtl/hb_mac.sv
module hb_mac #(
    parameter int DW   = 12,
    parameter int CW   = 16,
    parameter int NODD = 14,
    parameter int AW   = 36,
    parameter logic signed [CW-1:0] ODD_COEF [NODD] = '{default: '0},
    parameter logic signed [CW-1:0] CEN_COEF = '0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] pair_lo [NODD],
    input  logic signed [DW-1:0] pair_hi [NODD],
    input  logic signed [DW-1:0] mid,
    input  logic                 load,
    output logic signed [AW-1:0] y,
    output logic                 y_stb
);

    localparam int PW = DW + 1 + CW;

    logic signed [PW-1:0] prod [NODD];
    logic signed [PW-1:0] prod_c;
    logic signed [AW-1:0] sum;

    for (genvar i = 0; i < NODD; i++) begin : g_pair
        logic signed [DW:0] pre;
        assign pre     = (DW+1)'(pair_lo[i]) + (DW+1)'(pair_hi[i]);
        assign prod[i] = PW'(pre) * PW'(ODD_COEF[i]);
    end

    assign prod_c = PW'(mid) * PW'(CEN_COEF);

    always_comb begin
        sum = AW'(prod_c);
        for (int i = 0; i < NODD; i++) begin
            sum = sum + AW'(prod[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y     <= '0;
            y_stb <= 1'b0;
        end else begin
            y_stb <= load;
            if (load) y <= sum;
        end
    end

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(y) && !y_stb));

    // R2
    load_stb_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> y_stb);

endmodule

// File: rtl/hb_rate_filter.sv
module hb_rate_filter
    import hb_pkg::*;
#(
    parameter int DW   = 12,
    parameter int CW   = 16,
    parameter int NODD = 14,
    parameter int AW   = 36,
    parameter logic signed [CW-1:0] ODD_COEF [NODD] = '{
        16'sd10000, -16'sd3300, 16'sd1900, -16'sd1300, 16'sd950, -16'sd720,
        16'sd550, -16'sd420, 16'sd320, -16'sd240, 16'sd175, -16'sd125,
        16'sd85, -16'sd50},
    parameter logic signed [CW-1:0] CEN_COEF = 16'sd16384
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    input  logic          mode_a,
    input  logic          mode_b,
    input  logic          phase_mark,
    output logic [AW-1:0] acc_out,
    output logic          acc_stb
);

    hb_mode_e             mode;
    logic                 take;
    logic                 zero_in;
    logic                 load;
    logic signed [DW-1:0] pair_lo [NODD];
    logic signed [DW-1:0] pair_hi [NODD];
    logic signed [DW-1:0] mid;
    logic signed [AW-1:0] y;

    assign mode = decode_mode(mode_a, mode_b);

    always_comb begin
        zero_in = 1'b0;
        load    = 1'b1;
        unique case (mode)
            MODE_INTERP: zero_in = ~take;
            MODE_DECIM:  load    = take;
            default:     ;
        endcase
    end

    hb_phase_ctl u_phase (
        .clk        (clk),
        .rst        (rst),
        .phase_mark (phase_mark),
        .take       (take)
    );

    hb_tap_line #(.DW(DW), .NODD(NODD)) u_taps (
        .clk     (clk),
        .rst     (rst),
        .din     ($signed(din)),
        .zero_in (zero_in),
        .pair_lo (pair_lo),
        .pair_hi (pair_hi),
        .mid     (mid)
    );

    hb_mac #(
        .DW(DW), .CW(CW), .NODD(NODD), .AW(AW),
        .ODD_COEF(ODD_COEF), .CEN_COEF(CEN_COEF)
    ) u_mac (
        .clk     (clk),
        .rst     (rst),
        .pair_lo (pair_lo),
        .pair_hi (pair_hi),
        .mid     (mid),
        .load    (load),
        .y       (y),
        .y_stb   (acc_stb)
    );

    assign acc_out = y;

    // R2
    pass_stb_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PASS) |=> acc_stb);

    // R6
    decim_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_DECIM && !take) |=> !acc_stb);

endmodule

// File: tb/test_hb_rate_filter.sv
`timescale 1ns/1ps
module test_hb_rate_filter;

    localparam int DW = 12;
    localparam int CW = 16;
    localparam int NODD = 14;
    localparam int AW = 36;
    localparam int NT = 4*NODD - 1;
    localparam int MIDX = 2*NODD - 1;
    localparam logic signed [CW-1:0] ODDC [NODD] = '{
        16'sd10000, -16'sd3300, 16'sd1900, -16'sd1300, 16'sd950, -16'sd720,
        16'sd550, -16'sd420, 16'sd320, -16'sd240, 16'sd175, -16'sd125,
        16'sd85, -16'sd50};
    localparam logic signed [CW-1:0] CENC = 16'sd16384;

    logic          clk = 0;
    logic          rst = 1;
    logic [DW-1:0] din = '0;
    logic          mode_a = 0, mode_b = 0, phase_mark = 0;
    logic [AW-1:0] acc_out;
    logic          acc_stb;

    int checks = 0, errors = 0;
    bit done = 0;
    string tag = "R10";

    // model state
    longint c [NT];
    longint hist [NT];
    longint ym = 0;
    bit     sm = 0;
    bit     skip_m = 0;
    bit     mq = 0;

    always #2.5 clk = ~clk;

    hb_rate_filter #(.DW(DW), .CW(CW), .NODD(NODD), .AW(AW),
                     .ODD_COEF(ODDC), .CEN_COEF(CENC)) i_hb_rate_filter (
        .clk(clk), .rst(rst), .din(din), .mode_a(mode_a), .mode_b(mode_b),
        .phase_mark(phase_mark), .acc_out(acc_out), .acc_stb(acc_stb));

    initial begin
        for (int k = 0; k < NT; k++) c[k] = 0;
        c[MIDX] = CENC;
        for (int i = 0; i < NODD; i++) begin
            c[MIDX-(2*i+1)] = ODDC[i];
            c[MIDX+(2*i+1)] = ODDC[i];
        end
        for (int k = 0; k < NT; k++) hist[k] = 0;
    end

    // behavioural reference, advanced at every rising edge
    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NT; k++) hist[k] = 0;
            ym = 0; sm = 0; skip_m = 0; mq = 0;
        end else begin
            bit fall, tk, interp, decim, ld;
            longint acc;
            fall   = mq && !phase_mark;
            tk     = fall || !skip_m;
            interp = ({mode_a, mode_b} == 2'b01);
            decim  = ({mode_a, mode_b} == 2'b10);
            ld     = decim ? tk : 1'b1;
            acc = 0;
            for (int k = 0; k < NT; k++) acc += c[k] * hist[k];
            if (ld) ym = acc;
            sm = ld;
            for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = (interp && !tk) ? 0 : longint'($signed(din));
            skip_m = tk;
            mq = phase_mark;
        end
    end

    task automatic check_val(string t, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", t, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check_val(tag, longint'($signed(acc_out)), ym);
        check_val(tag, longint'(acc_stb), longint'(sm));
    endtask

    task automatic drive(logic a, logic b, logic m, logic [DW-1:0] d);
        mode_a = a; mode_b = b; phase_mark = m; din = d;
        step();
    endtask

    task automatic do_reset();
        rst = 1; din = '0; phase_mark = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        // R10 reset state
        check_val("R10", longint'($signed(acc_out)), 0);
        check_val("R10", longint'(acc_stb), 0);
        rst = 0;
    endtask

    initial begin
        @(negedge clk);
        // R10
        do_reset();

        // R4 impulse response in pass-through
        tag = "R4";
        drive(0, 0, 0, 12'sd1000);
        din = '0;
        repeat (26) step();
        step();
        check_val("R4", longint'($signed(acc_out)), 1000 * longint'(ODDC[0]));
        step();
        check_val("R4", longint'($signed(acc_out)), 1000 * longint'(CENC));
        step();
        check_val("R4", longint'($signed(acc_out)), 1000 * longint'(ODDC[0]));

        // R3 random samples, pass-through, plus full-scale extremes
        tag = "R3";
        for (int n = 0; n < 120; n++) drive(0, 0, 0, 12'($urandom));
        for (int n = 0; n < 60; n++) drive(0, 0, 0, (n % 2) ? 12'h800 : 12'h7FF);
        for (int n = 0; n < 60; n++) drive(0, 0, 0, 12'h800);

        // R2 pass-through strobe every cycle
        tag = "R2";
        for (int n = 0; n < 40; n++) begin
            drive(0, 0, 0, 12'($urandom));
            check_val("R2", longint'(acc_stb), 1);
        end

        // R1 the other equal setting also passes through
        tag = "R1";
        for (int n = 0; n < 80; n++) begin
            drive(1, 1, 0, 12'($urandom));
            check_val("R1", longint'(acc_stb), 1);
        end

        // R9 phase mark toggled in pass-through
        tag = "R9";
        for (int n = 0; n < 80; n++) drive(0, 0, 1'($urandom), 12'($urandom));

        // R7 decimation straight out of reset: first edge takes
        do_reset();
        tag = "R7";
        drive(1, 0, 0, 12'sd300);
        check_val("R7", longint'(acc_stb), 1);
        drive(1, 0, 0, 12'sd5);
        check_val("R7", longint'(acc_stb), 0);
        for (int n = 0; n < 60; n++) drive(1, 0, 0, 12'($urandom));

        // R5 interpolation, aligned with a mark
        tag = "R5";
        drive(0, 1, 1, 12'sd0);
        for (int n = 0; n < 120; n++) drive(0, 1, 0, 12'($urandom));

        // R8 realign at the opposite parity, then half-rate toggling mark
        tag = "R8";
        drive(0, 1, 1, 12'($urandom));
        drive(0, 1, 1, 12'($urandom));
        for (int n = 0; n < 60; n++) drive(0, 1, 0, 12'($urandom));
        for (int n = 0; n < 60; n++) drive(0, 1, n[0] ? 1'b0 : 1'b1, 12'($urandom));

        // R6 decimation with mark alignment and a later realign
        tag = "R6";
        drive(1, 0, 1, 12'($urandom));
        for (int n = 0; n < 70; n++) drive(1, 0, 0, 12'($urandom));
        drive(1, 0, 1, 12'($urandom));
        drive(1, 0, 1, 12'($urandom));
        for (int n = 0; n < 70; n++) drive(1, 0, 0, 12'($urandom));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule